// File: doc/BRIEF.md
# I2S to Simultaneous Serial Converter

This block turns a two-channel I2S stream into the two-line serial format that a multibit audio DAC expects. The I2S source delivers one data line with two 32-bit slots per frame, left first, on a bit clock at 64 times the sample rate. The block keeps the top 16 bits of each slot and flips their MSB, which changes a two's-complement sample into offset binary. It then sends the left and right words out at the same time on their own data lines, on a bit clock at one quarter of the input rate, with a latch strobe once per frame.

Everything runs from one fast system clock. The I2S bit clock, word select and data are sampled as ordinary inputs, and every action happens on a one-cycle tick at each rising edge of the input bit clock. The output bit clock is built from those ticks. It never stops, and it is realigned to the left-slot boundary, so that each frame holds exactly 16 output bit periods. A two-stage pair buffer lets the next frame be captured while the current pair is shifting out, which gives a fixed latency of one frame.

Top module: `i2s_sim_conv`

## Requirements
- R1: During reset and right after it, the output bit clock and the latch strobe are low and both data lines are high, which is the MSB of the word 0x8000.
- R2: Input is sampled on rising input bit-clock edges. Word select low selects the left channel. The MSB of each slot arrives one bit period after the word-select transition, and the left slot comes before the right slot.
- R3: Only the first 16 bits after each word-select transition are captured. The other 16 bits of the 32-bit slot have no effect on either output word.
- R4: Each output word is the upper 16 bits of its input slot with bit 15 inverted (word XOR 0x8000).
- R5: One output bit-clock period spans exactly 4 input bit periods, low for 2 and high for 2. The clock keeps toggling in every frame.
- R6: At every input tick where word select is first seen low, the output bit clock is driven low and a new 16-bit period begins, so that 16 output periods fill each 64-bit frame.
- R7: Both data lines change only when the output bit clock falls. They carry the left and right words in parallel, MSB first.
- R8: The latch strobe is high for exactly one output bit-clock period, the one that follows the 16th bit of a word, which is the first period of the next frame. It rises and falls only with a falling edge of the output bit clock, and it stays low in the first aligned frame after reset.
- R9: A stereo pair captured in input frame k is shifted out during frame k+1.
- R10: If no new pair has been captured when a frame starts, including the first frame after reset, both lines send 0x8000, which is a zero sample after MSB inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the I2S bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | I2S bit clock at 64 times the sample rate, sampled |
| ws_i | input | 1 | I2S word select, low for the left channel |
| sd_i | input | 1 | I2S serial data |
| bck_o | output | 1 | Output bit clock at 16 times the sample rate |
| le_o | output | 1 | Latch strobe, one output period per frame |
| dl_o | output | 1 | Left-channel serial data, MSB first |
| dr_o | output | 1 | Right-channel serial data, MSB first |

## Verification
The assertions assume a well-formed input. The bit clock is at least four system clocks per half period, word select and data change only while the bit clock is low, and word select flips every 32 bits, so that realignment never lands partway through an output period. The stimulus comes from a single bit-clock generator with a half period of four system clocks. Word select and data are updated only on its falling edges, and the frame begins with a short preamble that gives a clean first left-slot edge. The bench makes the upper slot halves and the discarded lower halves differ in every frame, so that a capture-window error shows up in the output words.

// File: rtl/i2s_sim_pkg.sv
// Shared constants and types for the I2S to simultaneous converter.
// Assumes the frame holds exactly SAMPLE_W output periods of OUT_DIV ticks.
package i2s_sim_pkg;
    localparam int SLOT_W      = 32;
    localparam int SAMPLE_W    = 16;
    localparam int OUT_DIV     = 4;
    localparam int FRAME_TICKS = 2 * SLOT_W;
    localparam int POS_W       = $clog2(FRAME_TICKS);
    localparam int DIV_W       = $clog2(OUT_DIV);
    localparam int CNT_W       = $clog2(SAMPLE_W + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    localparam sample_t MIDSCALE = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam pair_t   MID_PAIR = '{left: MIDSCALE, right: MIDSCALE};
endpackage

// File: rtl/i2s_sim_sync.sv
// Brings the I2S lines into the system clock domain and makes a one-cycle
// tick on each rising bit-clock edge, along with the word select and data
// sampled there and a flag for a word-select transition.
// Assumes each bit-clock half period lasts at least STAGES+1 system clocks.
module i2s_sim_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic tick_o,
    output logic ws_o,
    output logic sd_o,
    output logic ws_edge_o
);
    logic [STAGES-1:0] sck_sh, ws_sh, sd_sh;
    logic sck_last, ws_last;

    // synchronizer chains for all three inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sh   <= '0;
            ws_sh    <= '0;
            sd_sh    <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_sh   <= {sck_sh[STAGES-2:0], sck_i};
            ws_sh    <= {ws_sh[STAGES-2:0], ws_i};
            sd_sh    <= {sd_sh[STAGES-2:0], sd_i};
            sck_last <= sck_sh[STAGES-1];
        end
    end

    assign tick_o = sck_sh[STAGES-1] & ~sck_last;
    assign ws_o   = ws_sh[STAGES-1];
    assign sd_o   = sd_sh[STAGES-1];

    // word select seen at the previous tick
    always_ff @(posedge clk) begin
        if (!rst_n)      ws_last <= 1'b0;
        else if (tick_o) ws_last <= ws_o;
    end

    assign ws_edge_o = tick_o & (ws_o ^ ws_last);
endmodule

// File: rtl/i2s_sim_capture.sv
// Takes the 16 bits that follow each word-select transition, MSB first,
// inverts their MSB and pushes a pair once both slots of a frame are in.
// Assumes the left slot (word select low) comes before the right one.
module i2s_sim_capture
    import i2s_sim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  ws_i,
    input  logic  sd_i,
    input  logic  ws_edge_i,
    output logic  push_o,
    output pair_t pair_o
);
    logic [CNT_W-1:0] cnt;
    sample_t          sh;
    sample_t          left_q;
    logic             left_ok;
    sample_t          word;
    logic             last_bit;

    assign word     = {sh[SAMPLE_W-2:0], sd_i};
    assign last_bit = tick_i & ~ws_edge_i & (cnt == CNT_W'(SAMPLE_W - 1));

    // bit counter and shift register within one slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(SAMPLE_W);
            sh  <= '0;
        end else if (tick_i) begin
            if (ws_edge_i) begin
                cnt <= '0;
            end else if (cnt < CNT_W'(SAMPLE_W)) begin
                sh  <= word;
                cnt <= cnt + 1'b1;
            end
        end
    end

    // holds the left word until its right partner is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= MIDSCALE;
            left_ok <= 1'b0;
        end else if (last_bit) begin
            if (!ws_i) begin
                left_q  <= word ^ MIDSCALE;
                left_ok <= 1'b1;
            end else begin
                left_ok <= 1'b0;
            end
        end
    end

    // registered hand-off of a complete pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_o <= 1'b0;
            pair_o <= MID_PAIR;
        end else begin
            push_o <= last_bit & ws_i & left_ok;
            if (last_bit & ws_i) begin
                pair_o.left  <= left_q;
                pair_o.right <= word ^ MIDSCALE;
            end
        end
    end
endmodule

// File: rtl/i2s_sim_xbuf.sv
// Single-pair buffer between capture and shift-out. A push fills it and a
// frame-start pop empties it. When it is empty the reader gets midscale.
// Assumes at most one push per frame.
module i2s_sim_xbuf
    import i2s_sim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  pair_t pair_i,
    input  logic  pop_i,
    output pair_t pair_o
);
    pair_t slot;
    logic  full;

    // fill on push, drain on pop, push wins a collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= MID_PAIR;
            full <= 1'b0;
        end else if (push_i) begin
            slot <= pair_i;
            full <= 1'b1;
        end else if (pop_i) begin
            full <= 1'b0;
        end
    end

    assign pair_o = full ? slot : MID_PAIR;
endmodule

// File: rtl/i2s_sim_shifter.sv
// Keeps track of the tick position in the frame, makes the divided bit clock
// and the latch strobe, and shifts both words out in parallel.
// Assumes frame_start_i is a tick where word select has just gone low.
module i2s_sim_shifter
    import i2s_sim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  frame_start_i,
    input  pair_t pair_i,
    output logic  pop_o,
    output logic  bck_o,
    output logic  le_o,
    output logic  dl_o,
    output logic  dr_o
);
    logic [POS_W-1:0] pos, pos_nx;
    logic             primed;
    logic             period_start;
    sample_t          shl, shr;

    assign pos_nx       = frame_start_i ? '0 : pos + 1'b1;
    assign period_start = (pos_nx[DIV_W-1:0] == '0);
    assign pop_o        = tick_i & (pos_nx == '0);

    // frame position, divided clock and alignment flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '1;
            bck_o  <= 1'b0;
            primed <= 1'b0;
        end else if (tick_i) begin
            pos    <= pos_nx;
            bck_o  <= pos_nx[DIV_W-1];
            primed <= primed | frame_start_i;
        end
    end

    // latch strobe, changed only at the start of an output period
    always_ff @(posedge clk) begin
        if (!rst_n)                      le_o <= 1'b0;
        else if (tick_i && period_start) le_o <= frame_start_i & primed;
    end

    // parallel shift registers, loaded at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shl <= MIDSCALE;
            shr <= MIDSCALE;
        end else if (tick_i && period_start) begin
            if (pos_nx == '0) begin
                shl <= pair_i.left;
                shr <= pair_i.right;
            end else begin
                shl <= {shl[SAMPLE_W-2:0], 1'b0};
                shr <= {shr[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    assign dl_o = shl[SAMPLE_W-1];
    assign dr_o = shr[SAMPLE_W-1];
endmodule

// File: rtl/i2s_sim_conv.sv
// Top level: I2S input to a continuous divided bit clock, parallel
// left/right serial data and a per-frame latch strobe, one frame of latency.
// Assumes the system clock is well above four times the I2S bit clock.
module i2s_sim_conv
    import i2s_sim_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bck_o,
    output logic le_o,
    output logic dl_o,
    output logic dr_o
);
    logic  bit_tick, ws_s, sd_s, ws_edge, frame_start;
    logic  push, pop;
    pair_t cap_pair, rd_pair;

    assign frame_start = ws_edge & ~ws_s;

    i2s_sim_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
        .tick_o(bit_tick), .ws_o(ws_s), .sd_o(sd_s), .ws_edge_o(ws_edge)
    );

    i2s_sim_capture u_cap (
        .clk(clk), .rst_n(rst_n), .tick_i(bit_tick), .ws_i(ws_s),
        .sd_i(sd_s), .ws_edge_i(ws_edge), .push_o(push), .pair_o(cap_pair)
    );

    i2s_sim_xbuf u_buf (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pair_i(cap_pair),
        .pop_i(pop), .pair_o(rd_pair)
    );

    i2s_sim_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .tick_i(bit_tick),
        .frame_start_i(frame_start), .pair_i(rd_pair), .pop_o(pop),
        .bck_o(bck_o), .le_o(le_o), .dl_o(dl_o), .dr_o(dr_o)
    );
endmodule

// File: rtl/i2s_sim_conv_chk.sv
// Property checker for i2s_sim_conv, attached with bind.
// Assumes well-formed I2S input, as the brief describes.
module i2s_sim_conv_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic frame_start,
    input logic bck,
    input logic le,
    input logic dl,
    input logic dr
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bck && !le && dl && dr));

    // R5
    bck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bck));

    // R6
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !bck);

    // R7
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bck) |-> ($stable(dl) && $stable(dr)));

    // R8
    le_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le) |-> $fell(bck));

    // R8
    le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le) |-> $fell(bck));
endmodule

bind i2s_sim_conv i2s_sim_conv_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .frame_start(frame_start),
    .bck(bck_o), .le(le_o), .dl(dl_o), .dr(dr_o)
);

// File: tb/i2s_sim_conv_tb.sv
// Scoreboard bench: the driver sends I2S frames and queues the expected
// output pairs, and the monitor rebuilds words from the output lines.
module i2s_sim_conv_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, ws = 1'b1, sd = 1'b0;
    logic bck, le, dl, dr;

    int checks = 0, fails = 0;
    logic [31:0] exp_q[$];
    bit done = 1'b0;

    i2s_sim_conv u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
        .bck_o(bck), .le_o(le), .dl_o(dl), .dr_o(dr)
    );

    always #5 clk = ~clk;

    initial begin
        #40;
        forever #40 sck = ~sck;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one 64-bit I2S frame, expected pair queued first (R2, R3, R4)
    task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
        exp_q.push_back({l[31:16] ^ 16'h8000, r[31:16] ^ 16'h8000});
        for (int j = 0; j < 64; j++) begin
            @(negedge sck);
            ws = (j >= 31 && j < 63);
            sd = (j < 32) ? l[31-j] : r[63-j];
        end
    endtask

    // monitor
    int   cyc = 0, last_rise = 0, ws_fall_cyc = 0, since_le = 0;
    bit   locked = 1'b0, prev_locked = 1'b0;
    logic bck_q = 1'b0, ws_q = 1'b1;
    logic [15:0] wl = '0, wr = '0;

    always @(negedge clk) begin
        cyc++;
        if (ws_q && !ws) ws_fall_cyc = cyc;
        ws_q = ws;
        if (rst_n && !bck_q && bck) begin
            if (le) begin
                if (!locked) begin
                    // R10: first aligned frame sends midscale
                    check("R10", {wl, wr}, 32'h8000_8000);
                    locked = 1'b1;
                end else begin
                    // R8: one strobe every 16 output periods
                    check("R8", since_le, 16);
                    // R6: strobe period starts a fixed distance after ws falls
                    check("R6", ((cyc - ws_fall_cyc) >= 16 && (cyc - ws_fall_cyc) < 32), 1);
                    if (exp_q.size() > 0) begin
                        // R4 R7 R9: words match the pair from the previous frame
                        check("R9", {wl, wr}, exp_q.pop_front());
                    end
                end
                since_le = 0;
            end
            if (prev_locked) begin
                // R5: 4 input bits of 8 system clocks each
                check("R5", cyc - last_rise, 32);
            end
            prev_locked = locked;
            last_rise = cyc;
            wl = {wl[14:0], dl};
            wr = {wr[14:0], dr};
            since_le++;
        end
        bck_q = bck;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state while in reset
        check("R1", {28'd0, bck, le, dl, dr}, 32'h3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {28'd0, bck, le, dl, dr}, 32'h3);
        // preamble: three right-slot bits, then the left edge bit
        for (int k = 0; k < 4; k++) begin
            @(negedge sck);
            ws = (k < 3);
            sd = 1'b0;
        end
        send_frame(32'h1234_ABCD, 32'hFEDC_5432);
        send_frame(32'h0000_FFFF, 32'hFFFF_0000);
        send_frame(32'h7FFF_0000, 32'h8000_FFFF);
        send_frame(32'h8000_7FFF, 32'h7FFF_8000);
        send_frame(32'hAAAA_5555, 32'h5555_AAAA);
        send_frame(32'hFFFF_FFFF, 32'h0001_FFFE);
        for (int k = 0; k < 6; k++) begin
            send_frame($urandom, $urandom);
        end
        send_frame(32'h0, 32'h0);
        send_frame(32'h0, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #3_000_000;
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule